// File: doc/BRIEF.md
# Multi-Region Access Protection Checker

This block screens every processor bus transaction against eight programmable address windows. Each window covers whole 1 MB pages, set by an inclusive lower page and an inclusive upper page taken from address bits 31:20. A window also carries three independent protection attributes: one that forbids any access, one that forbids writes, and one that forbids caching, which is a block (burst) read. Separately from the windows, a burst aimed at internal register space is reported as a transfer-type violation.

Software programs each window through a simple write port. Every window has two words: a lower word holding the lower page and the protection attributes, and an upper word holding the upper page. A request is presented for one cycle with a valid strobe. The four violation flags appear on the next cycle, together with a response strobe. Logging and interrupt generation belong to a neighbouring block.

Top module: `region_guard`

## Requirements
- R1: After reset every window has zero bounds and no protection attributes set, and all outputs are low.
- R2: `rspValid` rises exactly one cycle after a cycle with `reqValid` high. In a cycle with `rspValid` low, all four violation flags are low.
- R3: A window is hit when address bits 31:20 are greater than or equal to its lower page and less than or equal to its upper page. Both bounds are inclusive. A window whose lower page exceeds its upper page is never hit.
- R4: Lower-word bit 16 set on a hit window raises `accViol` for any request type.
- R5: Lower-word bit 17 set on a hit window raises `wrViol` only when `reqWrite` is 1.
- R6: Lower-word bit 18 set on a hit window raises `cacheViol` only for a burst read (`reqBurst`=1, `reqWrite`=0).
- R7: `ttViol` is raised for any request with both `reqBurst` and `reqRegSpace` high, independent of the windows.
- R8: When several windows are hit, each flag is the OR of the matching attribute across all hit windows.
- R9: Lower-word bits 15:12 and 31:19, and upper-word bits 31:12, are ignored. Writing them changes no flag.
- R10: A window write takes effect for requests in later cycles. A request in the same cycle as the write is judged on the previous settings.
- R11: Address bits 19:0 have no effect on any flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Window register write strobe |
| cfgWrHigh | input | 1 | 0 selects the lower word, 1 selects the upper word |
| cfgWrIdx | input | 3 | Window number to write |
| cfgWrData | input | 32 | Write data; lower word: [11:0] page, [16] deny all, [17] deny write, [18] deny block read; upper word: [11:0] page |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | 32 | Request address |
| reqWrite | input | 1 | 1 for a write, 0 for a read |
| reqBurst | input | 1 | 1 for a burst (block) transfer |
| reqRegSpace | input | 1 | Request targets internal register space |
| rspValid | output | 1 | Flags below belong to the previous cycle's request |
| accViol | output | 1 | Access-forbidden violation |
| wrViol | output | 1 | Write-protect violation |
| cacheViol | output | 1 | Caching (block read) violation |
| ttViol | output | 1 | Burst to register space violation |

## Verification
The hardest case to reach from the ports is a request that lands in the same cycle as a write to the window it hits. Only that case shows whether the compare uses the settings from before or after the write. The bench drives both strobes on one edge and checks that the first response ignores the new attribute while the following response shows it. Overlapping windows whose attributes differ, and single-page windows hit at their exact page, are set up ahead of the vector table. This makes the inclusive bounds and the OR across windows visible in individual flags.

// File: rtl/region_guard_pkg.sv
package region_guard_pkg;
  localparam int ADDR_W       = 32;
  localparam int PAGE_LSB     = 20;
  localparam int PAGE_W       = ADDR_W - PAGE_LSB;
  localparam int NUM_WIN      = 8;
  localparam int WIN_IDX_W    = $clog2(NUM_WIN);
  localparam int BIT_DENY_ALL = 16;
  localparam int BIT_DENY_WR  = 17;
  localparam int BIT_DENY_BLK = 18;

  typedef struct packed {
    logic [PAGE_W-1:0] loPage;
    logic [PAGE_W-1:0] hiPage;
    logic              denyAll;
    logic              denyWr;
    logic              denyBlk;
  } winCfg_t;

  typedef struct packed {
    logic                 wrLow;
    logic                 wrHigh;
    logic [WIN_IDX_W-1:0] idx;
    logic                 capture;
    logic                 isWrite;
    logic                 isBlkRead;
    logic                 isTT;
  } ctlStrobe_t;
endpackage

// File: rtl/rg_ctrl.sv
module rg_ctrl
  import region_guard_pkg::*;
(
  input  logic                 cfgWrEn,
  input  logic                 cfgWrHigh,
  input  logic [WIN_IDX_W-1:0] cfgWrIdx,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqBurst,
  input  logic                 reqRegSpace,
  output ctlStrobe_t           stb
);
  always_comb begin
    stb           = '0;
    stb.wrLow     = cfgWrEn && !cfgWrHigh;
    stb.wrHigh    = cfgWrEn && cfgWrHigh;
    stb.idx       = cfgWrIdx;
    stb.capture   = reqValid;
    stb.isWrite   = reqValid && reqWrite;
    stb.isBlkRead = reqValid && reqBurst && !reqWrite;
    stb.isTT      = reqValid && reqBurst && reqRegSpace;
  end
endmodule

// File: rtl/rg_datapath.sv
module rg_datapath
  import region_guard_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        stb,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic              accViol,
  output logic              wrViol,
  output logic              cacheViol,
  output logic              ttViol
);
  winCfg_t             win [NUM_WIN];
  logic [NUM_WIN-1:0]  hitMask;
  logic [NUM_WIN-1:0]  allMask, wrMask, blkMask;
  logic [PAGE_W-1:0]   reqPage;

  assign reqPage = reqAddr[ADDR_W-1:PAGE_LSB];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_ff @(posedge clk) begin
      if (!rstN) begin
        win[w] <= '0;
      end else if (stb.wrLow && stb.idx == WIN_IDX_W'(w)) begin
        win[w].loPage  <= cfgWrData[PAGE_W-1:0];
        win[w].denyAll <= cfgWrData[BIT_DENY_ALL];
        win[w].denyWr  <= cfgWrData[BIT_DENY_WR];
        win[w].denyBlk <= cfgWrData[BIT_DENY_BLK];
      end else if (stb.wrHigh && stb.idx == WIN_IDX_W'(w)) begin
        win[w].hiPage  <= cfgWrData[PAGE_W-1:0];
      end
    end

    assign hitMask[w] = (reqPage >= win[w].loPage) && (reqPage <= win[w].hiPage);
    assign allMask[w] = hitMask[w] && win[w].denyAll;
    assign wrMask[w]  = hitMask[w] && win[w].denyWr;
    assign blkMask[w] = hitMask[w] && win[w].denyBlk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid  <= 1'b0;
      accViol   <= 1'b0;
      wrViol    <= 1'b0;
      cacheViol <= 1'b0;
      ttViol    <= 1'b0;
    end else begin
      rspValid  <= stb.capture;
      accViol   <= stb.capture && (|allMask);
      wrViol    <= stb.isWrite && (|wrMask);
      cacheViol <= stb.isBlkRead && (|blkMask);
      ttViol    <= stb.isTT;
    end
  end

  // R2: no flag without a response
  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !rspValid |-> !(accViol || wrViol || cacheViol || ttViol));
  // R4: a window flag needs a hit in the request cycle
  a_r4_flag_needs_hit: assert property (@(posedge clk) disable iff (!rstN)
    (accViol || wrViol || cacheViol) |-> $past(|hitMask));
  // R5: write protection only fires for writes
  a_r5_wr_only_writes: assert property (@(posedge clk) disable iff (!rstN)
    wrViol |-> $past(stb.isWrite));
  // R6: cache protection only fires for block reads
  a_r6_blk_only_reads: assert property (@(posedge clk) disable iff (!rstN)
    cacheViol |-> $past(stb.isBlkRead));
  // R7: transfer-type flag needs a burst
  a_r7_tt_needs_burst: assert property (@(posedge clk) disable iff (!rstN)
    ttViol |-> $past(stb.isTT));
endmodule

// File: rtl/region_guard.sv
module region_guard
  import region_guard_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWrEn,
  input  logic                 cfgWrHigh,
  input  logic [WIN_IDX_W-1:0] cfgWrIdx,
  input  logic [ADDR_W-1:0]    cfgWrData,
  input  logic                 reqValid,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqWrite,
  input  logic                 reqBurst,
  input  logic                 reqRegSpace,
  output logic                 rspValid,
  output logic                 accViol,
  output logic                 wrViol,
  output logic                 cacheViol,
  output logic                 ttViol
);
  ctlStrobe_t stb;

  rg_ctrl u_ctrl (
    .cfgWrEn     (cfgWrEn),
    .cfgWrHigh   (cfgWrHigh),
    .cfgWrIdx    (cfgWrIdx),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqBurst    (reqBurst),
    .reqRegSpace (reqRegSpace),
    .stb         (stb)
  );

  rg_datapath u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .cfgWrData (cfgWrData),
    .reqAddr   (reqAddr),
    .rspValid  (rspValid),
    .accViol   (accViol),
    .wrViol    (wrViol),
    .cacheViol (cacheViol),
    .ttViol    (ttViol)
  );

  // R2: a request is always answered on the next cycle
  a_r2_rsp_after_req: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
endmodule

// File: tb/test_region_guard.sv
module test_region_guard;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgWrHigh = 1'b0;
  logic [2:0]  cfgWrIdx = '0;
  logic [31:0] cfgWrData = '0;
  logic        reqValid = 1'b0, reqWrite = 1'b0, reqBurst = 1'b0, reqRegSpace = 1'b0;
  logic [31:0] reqAddr = '0;
  logic        rspValid, accViol, wrViol, cacheViol, ttViol;

  int vecCount = 0;
  int failCount = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  region_guard i_region_guard (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrHigh(cfgWrHigh),
    .cfgWrIdx(cfgWrIdx), .cfgWrData(cfgWrData), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqBurst(reqBurst),
    .reqRegSpace(reqRegSpace), .rspValid(rspValid), .accViol(accViol),
    .wrViol(wrViol), .cacheViol(cacheViol), .ttViol(ttViol)
  );

  // expected flags: [3] access, [2] write, [1] cache, [0] transfer type
  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic        burst;
    logic        rs;
    logic [3:0]  exp;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{32'h0FFF_FFFF, 1'b0, 1'b0, 1'b0, 4'b0000}, // R3 just below lower page
    '{32'h1000_0000, 1'b0, 1'b0, 1'b0, 4'b1000}, // R3 R4 lower bound inclusive
    '{32'h1FFF_FFFF, 1'b1, 1'b0, 1'b0, 4'b1000}, // R4 upper bound, write
    '{32'h2000_0000, 1'b0, 1'b0, 1'b0, 4'b0000}, // R5 read of write-protected
    '{32'h2000_0000, 1'b1, 1'b0, 1'b0, 4'b0100}, // R5 write
    '{32'h2FF1_2345, 1'b0, 1'b1, 1'b0, 4'b0010}, // R8 overlap burst read
    '{32'h2FF0_0000, 1'b1, 1'b1, 1'b0, 4'b0100}, // R6 burst write not cache
    '{32'h3000_0000, 1'b0, 1'b1, 1'b0, 4'b0010}, // R6 single-page window
    '{32'h300F_FFFF, 1'b0, 1'b0, 1'b0, 4'b0000}, // R6 R11 single read
    '{32'h3010_0000, 1'b0, 1'b1, 1'b0, 4'b0000}, // R3 above upper page
    '{32'h4500_0000, 1'b1, 1'b0, 1'b0, 4'b0000}, // R3 inverted window
    '{32'hF000_0000, 1'b0, 1'b1, 1'b1, 4'b0001}, // R7 burst to registers
    '{32'h1000_0000, 1'b1, 1'b1, 1'b1, 4'b1001}, // R7 R4 both at once
    '{32'hF000_0000, 1'b0, 1'b0, 1'b1, 4'b0000}, // R7 single to registers
    '{32'h2F0A_BCDE, 1'b1, 1'b1, 1'b0, 4'b0100}  // R8 R11 overlap write
  };

  task automatic check(input string req, input logic [4:0] act, input logic [4:0] exp);
    vecCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {rspValid, accViol, wrViol, cacheViol, ttViol};
  endfunction

  task automatic cfgWrite(input int idx, input bit high, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrHigh = high; cfgWrIdx = 3'(idx); cfgWrData = data;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic request(input logic [31:0] a, input logic w, input logic b, input logic r,
                         input logic [3:0] exp, input string req);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = w; reqBurst = b; reqRegSpace = r;
    @(negedge clk);
    reqValid = 1'b0;
    check(req, outs(), {1'b1, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 outputs in reset", outs(), 5'b0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", outs(), 5'b0);
    request(32'h0000_0000, 1'b1, 1'b1, 1'b0, 4'b0000, "R1 cleared windows");
    @(negedge clk);
    check("R2 idle cycle quiet", outs(), 5'b0);

    cfgWrite(0, 0, 32'h0001_0100); cfgWrite(0, 1, 32'h0000_01FF);
    cfgWrite(1, 0, 32'h0002_0200); cfgWrite(1, 1, 32'h0000_02FF);
    cfgWrite(2, 0, 32'h0004_0300); cfgWrite(2, 1, 32'h0000_0300);
    cfgWrite(3, 0, 32'h0004_02F0); cfgWrite(3, 1, 32'h0000_02FF);
    cfgWrite(4, 0, 32'h0001_0500); cfgWrite(4, 1, 32'h0000_0400);

    for (int i = 0; i < NVEC; i++)
      request(VECS[i].addr, VECS[i].wr, VECS[i].burst, VECS[i].rs, VECS[i].exp,
              $sformatf("vector %0d", i));

    // R9: reserved bits set, no protection bits
    cfgWrite(5, 0, 32'hFFF8_F600); cfgWrite(5, 1, 32'hFFFF_F600);
    request(32'h6000_0000, 1'b1, 1'b1, 1'b0, 4'b0000, "R9 reserved write ignored");
    request(32'h6000_0000, 1'b0, 1'b1, 1'b0, 4'b0000, "R9 reserved read ignored");

    // R10: same-cycle write and request
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrHigh = 1'b0; cfgWrIdx = 3'd5; cfgWrData = 32'h0001_0600;
    reqValid = 1'b1; reqAddr = 32'h6000_0000; reqWrite = 1'b0; reqBurst = 1'b0; reqRegSpace = 1'b0;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    check("R10 same cycle uses old settings", outs(), 5'b10000);
    request(32'h6000_0000, 1'b0, 1'b0, 1'b0, 4'b1000, "R10 new settings next");
    @(negedge clk);
    check("R2 idle after request", outs(), 5'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", vecCount, failCount);
      $finish;
    end
  end
endmodule